// File: doc/BRIEF.md
# Quarter-Bin Twiddle Rotator for a Cosine Transform

This block sits between a complex FFT and the real-valued coefficients of a discrete cosine transform. One complex sample enters per cycle, together with its bin index k. In the forward direction the sample is rotated by twice a quarter-bin phase factor, exp(-jπk/2N). The real part of the product becomes coefficient k, and the negated imaginary part becomes the coefficient at the mirrored index N-k.

In the inverse direction the block takes a pair of coefficients, X(k) and X(N-k). It builds the complex value X(k) - j·X(N-k) and rotates it by twice the conjugate factor. The two halves of the result are then ready for an inverse FFT. One datapath serves both directions and both transform lengths, 512 and 1024.

The cosine and sine terms come from a single table computed for the longest length. At the shorter length that table is read at 2k. Every result is rounded and clipped back to the data width. A sticky flag records whether any value in the current block had to be clipped.

Top module: `rbr_rotator`

## Requirements
- R1: Forward (in_dir=0): with a=in_re, b=in_im, c=round(cos θ·2^16), s=round(sin θ·2^16), θ=π·idx/2048, and idx=k·(1024/N), out_a = sat(floor((a·c + b·s)/2^15 + 1/2)) and out_ka = k.
- R2: Forward: out_b = sat(floor((a·s - b·c)/2^15 + 1/2)), which is the negated imaginary part of the rotated product, and out_kb = N-k.
- R3: Forward with k=0: out_b_valid stays low while out_valid is high, out_kb reads 0, and the imaginary result is not counted for overflow.
- R4: Inverse (in_dir=1): a=in_re and b=-in_im (b=0 when k=0). Then out_a = sat(floor((a·c - b·s)/2^15 + 1/2)) and out_b = sat(floor((b·c + a·s)/2^15 + 1/2)). Both out_ka and out_kb equal k, and out_b_valid is high.
- R5: A sample accepted with in_valid high appears with out_valid high exactly 10 clock cycles later. One sample per cycle is accepted with no gaps. out_valid is low in every other cycle.
- R6: in_half=0 selects N=1024. in_half=1 selects N=512, and in that mode bit 9 of in_k is ignored: k is taken as in_k mod 512.
- R7: Results outside the signed 24-bit range are clipped to 8388607 or -8388608.
- R8: out_ovf rises with the first output whose out_a (or out_b, when out_b_valid) was clipped. It stays high until a sample marked with in_sof reaches the output. That sample restarts the flag from its own clipping.
- R9: While rst_n is low, out_valid, out_b_valid and out_ovf are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_sof | input | 1 | First sample of a block; restarts the overflow flag |
| in_dir | input | 1 | 0 forward, 1 inverse |
| in_half | input | 1 | 0 for length 1024, 1 for length 512 |
| in_k | input | 10 | Bin index k |
| in_re | input | 24 | Forward: Re V(k); inverse: X(k) |
| in_im | input | 24 | Forward: Im V(k); inverse: X(N-k) |
| out_valid | output | 1 | Output sample present |
| out_a | output | 24 | Real result |
| out_ka | output | 10 | Index of out_a |
| out_b | output | 24 | Second result (negated imaginary forward, imaginary inverse) |
| out_kb | output | 10 | Index of out_b |
| out_b_valid | output | 1 | out_b carries a coefficient |
| out_ovf | output | 1 | Sticky clipping flag for the current block |

## Verification
The bench builds the block with its default parameters: 24-bit data, 18-bit twiddles, a 1024-entry table and a latency of 10. With these values both run-time lengths can be exercised. So can full-scale inputs whose rotated sums exceed the data range in either sign. The padding section of the pipeline (four stages) also sees back-to-back traffic, gaps, and alternating directions. The reference model recomputes every twiddle from real cosines and sines, and recomputes each rounded product in floating point. It checks the outputs on every clock against a cycle-indexed schedule.

// File: rtl/rbr_pkg.sv
`timescale 1ns/1ps
package rbr_pkg;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_INV = 1'b1
  } rbr_dir_e;

  localparam real RBR_PI = 3.14159265358979323846;

  // Quantised quarter-wave twiddle: nearest integer of trig(pi*idx/(2*nmax)) * 2^frac
  function automatic int tw_quant(int idx, int nmax, int frac, bit want_sin);
    real th;
    real v;
    th = RBR_PI * idx / (2.0 * nmax);
    v  = want_sin ? $sin(th) : $cos(th);
    return $rtoi($floor(v * (2.0 ** frac) + 0.5));
  endfunction

endpackage

// File: rtl/rbr_delay.sv
`timescale 1ns/1ps
module rbr_delay #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  if (DEPTH == 0) begin : g_wire
    assign q = d;
  end else begin : g_pipe
    logic [WIDTH-1:0] sr [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
      end else begin
        sr[0] <= d;
        for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
      end
    end
    assign q = sr[DEPTH-1];
  end

endmodule

// File: rtl/rbr_twiddle_rom.sv
`timescale 1ns/1ps
module rbr_twiddle_rom #(
  parameter int NMAX = 1024,
  parameter int TW   = 18
) (
  input  logic                      clk,
  input  logic [$clog2(NMAX)-1:0]   addr,
  output logic signed [TW-1:0]      cos_q,
  output logic signed [TW-1:0]      sin_q
);

  localparam int FR = TW - 2;

  logic signed [TW-1:0] cos_tab [NMAX];
  logic signed [TW-1:0] sin_tab [NMAX];

  for (genvar i = 0; i < NMAX; i++) begin : g_tab
    localparam int CV = rbr_pkg::tw_quant(i, NMAX, FR, 1'b0);
    localparam int SV = rbr_pkg::tw_quant(i, NMAX, FR, 1'b1);
    assign cos_tab[i] = TW'(CV);
    assign sin_tab[i] = TW'(SV);
  end

  always_ff @(posedge clk) begin
    cos_q <= cos_tab[addr];
    sin_q <= sin_tab[addr];
  end

endmodule

// File: rtl/rbr_cmul.sv
`timescale 1ns/1ps
module rbr_cmul #(
  parameter int W  = 24,
  parameter int TW = 18
) (
  input  logic                clk,
  input  logic                dir_inv,
  input  logic signed [W:0]   a,
  input  logic signed [W:0]   b,
  input  logic signed [TW-1:0] c,
  input  logic signed [TW-1:0] s,
  output logic signed [W-1:0] re_q,
  output logic signed [W-1:0] im_q,
  output logic                sat_re,
  output logic                sat_im
);

  localparam int PW = W + 1 + TW;
  localparam int SW = PW + 1;
  localparam int SH = TW - 3;        // twiddle scale 2^(TW-2), times the factor 2
  localparam int QW = SW - SH + 1;
  localparam logic signed [SW:0]   HALF_LSB = (SW+1)'(1) <<< (SH - 1);
  localparam logic signed [QW-1:0] QMAX = QW'((longint'(1) <<< (W - 1)) - 1);
  localparam logic signed [QW-1:0] QMIN = QW'(-(longint'(1) <<< (W - 1)));

  // round half upward, then clip; returns {clipped, value}
  function automatic logic [W:0] rnd_sat(input logic signed [SW-1:0] v);
    logic signed [SW:0]   t;
    logic signed [QW-1:0] q;
    t = (SW+1)'(v) + HALF_LSB;
    q = QW'(t >>> SH);
    if (q > QMAX) return {1'b1, QMAX[W-1:0]};
    else if (q < QMIN) return {1'b1, QMIN[W-1:0]};
    return {1'b0, q[W-1:0]};
  endfunction

  logic signed [PW-1:0] p_ac, p_bs, p_bc, p_as;
  logic                 inv3;
  logic signed [SW-1:0] s_re, s_im;

  always_ff @(posedge clk) begin
    p_ac <= PW'(a) * PW'(c);
    p_bs <= PW'(b) * PW'(s);
    p_bc <= PW'(b) * PW'(c);
    p_as <= PW'(a) * PW'(s);
    inv3 <= dir_inv;
  end

  // negation of the forward imaginary part is folded into the sum
  always_ff @(posedge clk) begin
    if (inv3) begin
      s_re <= SW'(p_ac) - SW'(p_bs);
      s_im <= SW'(p_bc) + SW'(p_as);
    end else begin
      s_re <= SW'(p_ac) + SW'(p_bs);
      s_im <= SW'(p_as) - SW'(p_bc);
    end
  end

  always_ff @(posedge clk) begin
    {sat_re, re_q} <= rnd_sat(s_re);
    {sat_im, im_q} <= rnd_sat(s_im);
  end

endmodule

// File: rtl/rbr_rotator.sv
`timescale 1ns/1ps
module rbr_rotator #(
  parameter int W    = 24,
  parameter int TW   = 18,
  parameter int NMAX = 1024,
  parameter int LAT  = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_sof,
  input  logic                      in_dir,
  input  logic                      in_half,
  input  logic [$clog2(NMAX)-1:0]   in_k,
  input  logic signed [W-1:0]       in_re,
  input  logic signed [W-1:0]       in_im,
  output logic                      out_valid,
  output logic signed [W-1:0]       out_a,
  output logic [$clog2(NMAX)-1:0]   out_ka,
  output logic signed [W-1:0]       out_b,
  output logic [$clog2(NMAX)-1:0]   out_kb,
  output logic                      out_b_valid,
  output logic                      out_ovf
);

  localparam int KW  = $clog2(NMAX);
  localparam int SBW = 4 + 2 * KW;          // valid, sof, inv, k0, ka, kb
  localparam int PAD = LAT - 6;             // stages between rounding and output
  localparam int BW  = SBW + 2 * W + 2;

  // ---- stage 1: index folding and complex operand forming ----
  logic [KW-1:0] k_eff, mir_k;
  logic          k_zero;
  logic [KW:0]   n_len;

  assign k_eff  = in_half ? {1'b0, in_k[KW-2:0]} : in_k;
  assign k_zero = (k_eff == '0);
  assign n_len  = in_half ? (KW+1)'(NMAX / 2) : (KW+1)'(NMAX);
  assign mir_k  = KW'(n_len - {1'b0, k_eff});

  logic              s1_v, s1_sof, s1_inv, s1_half, s1_k0;
  logic [KW-1:0]     s1_k, s1_kb;
  logic signed [W:0] s1_a, s1_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_sof <= 1'b0; s1_inv <= 1'b0; s1_half <= 1'b0; s1_k0 <= 1'b0;
      s1_k <= '0; s1_kb <= '0; s1_a <= '0; s1_b <= '0;
    end else begin
      s1_v    <= in_valid;
      s1_sof  <= in_sof;
      s1_inv  <= (in_dir == rbr_pkg::DIR_INV);
      s1_half <= in_half;
      s1_k0   <= k_zero;
      s1_k    <= k_eff;
      s1_a    <= (W+1)'(in_re);
      if (in_dir == rbr_pkg::DIR_INV) begin
        s1_kb <= k_eff;
        s1_b  <= k_zero ? '0 : -((W+1)'(in_im));
      end else begin
        s1_kb <= k_zero ? '0 : mir_k;
        s1_b  <= (W+1)'(in_im);
      end
    end
  end

  // ---- stage 2: single table, read at 2k for the half length ----
  logic [KW-1:0]        rom_addr;
  logic signed [TW-1:0] tw_c, tw_s;
  logic signed [W:0]    s2_a, s2_b;
  logic                 s2_inv;

  assign rom_addr = s1_half ? {s1_k[KW-2:0], 1'b0} : s1_k;

  rbr_twiddle_rom #(.NMAX(NMAX), .TW(TW)) u_rom (
    .clk(clk), .addr(rom_addr), .cos_q(tw_c), .sin_q(tw_s)
  );

  always_ff @(posedge clk) begin
    s2_a   <= s1_a;
    s2_b   <= s1_b;
    s2_inv <= s1_inv;
  end

  // ---- stages 3..5: multiply, sum, round and clip ----
  logic signed [W-1:0] r5_re, r5_im;
  logic                r5_sre, r5_sim;

  rbr_cmul #(.W(W), .TW(TW)) u_cmul (
    .clk(clk), .dir_inv(s2_inv), .a(s2_a), .b(s2_b), .c(tw_c), .s(tw_s),
    .re_q(r5_re), .im_q(r5_im), .sat_re(r5_sre), .sat_im(r5_sim)
  );

  logic [SBW-1:0] sb1, sb5;
  assign sb1 = {s1_v, s1_sof, s1_inv, s1_k0, s1_k, s1_kb};

  rbr_delay #(.WIDTH(SBW), .DEPTH(4)) u_sb_dly (
    .clk(clk), .rst_n(rst_n), .d(sb1), .q(sb5)
  );

  // ---- padding to the fixed latency ----
  logic [BW-1:0] bnd5, bndf;
  assign bnd5 = {sb5, r5_re, r5_im, r5_sre, r5_sim};

  rbr_delay #(.WIDTH(BW), .DEPTH(PAD)) u_pad_dly (
    .clk(clk), .rst_n(rst_n), .d(bnd5), .q(bndf)
  );

  logic                f_v, f_sof, f_inv, f_k0, f_sre, f_sim;
  logic [KW-1:0]       f_ka, f_kb;
  logic signed [W-1:0] f_re, f_im;
  logic                b_keep;
  logic                sat_evt;   // a kept result was clipped (also observed by the checker)

  assign {f_v, f_sof, f_inv, f_k0, f_ka, f_kb, f_re, f_im, f_sre, f_sim} = bndf;
  assign b_keep  = f_inv | ~f_k0;
  assign sat_evt = f_v & (f_sre | (f_sim & b_keep));

  // ---- final stage: outputs and per-block sticky flag ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_b_valid <= 1'b0; out_ovf <= 1'b0;
      out_a <= '0; out_b <= '0; out_ka <= '0; out_kb <= '0;
    end else begin
      out_valid   <= f_v;
      out_b_valid <= f_v & b_keep;
      out_a       <= f_re;
      out_b       <= f_im;
      out_ka      <= f_ka;
      out_kb      <= f_kb;
      if (f_v) out_ovf <= (out_ovf & ~f_sof) | sat_evt;
    end
  end

endmodule

// File: rtl/rbr_rotator_chk.sv
`timescale 1ns/1ps
module rbr_rotator_chk #(
  parameter int NMAX = 1024,
  parameter int LAT  = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_sof,
  input logic                    in_dir,
  input logic                    in_half,
  input logic [$clog2(NMAX)-1:0] in_k,
  input logic                    out_valid,
  input logic [$clog2(NMAX)-1:0] out_ka,
  input logic [$clog2(NMAX)-1:0] out_kb,
  input logic                    out_b_valid,
  input logic                    out_ovf,
  input logic                    sat_evt
);

  localparam int KW = $clog2(NMAX);

  logic          in_k0;
  logic [LAT-1:0] h_v, h_sof, h_inv, h_k0, h_half;

  assign in_k0 = in_half ? (in_k[KW-2:0] == '0) : (in_k == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_v <= '0; h_sof <= '0; h_inv <= '0; h_k0 <= '0; h_half <= '0;
    end else begin
      h_v    <= {h_v[LAT-2:0], in_valid};
      h_sof  <= {h_sof[LAT-2:0], in_sof};
      h_inv  <= {h_inv[LAT-2:0], in_dir};
      h_k0   <= {h_k0[LAT-2:0], in_k0};
      h_half <= {h_half[LAT-2:0], in_half};
    end
  end

  logic          o_inv, o_k0, o_sofv;
  logic [KW:0]   o_len;
  assign o_inv  = h_inv[LAT-1];
  assign o_k0   = h_k0[LAT-1];
  assign o_sofv = h_v[LAT-1] & h_sof[LAT-1];
  assign o_len  = h_half[LAT-1] ? (KW+1)'(NMAX / 2) : (KW+1)'(NMAX);

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == h_v[LAT-1]);

  assert_bvalid_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_b_valid |-> out_valid);

  assert_k0_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !o_inv && o_k0) |-> !out_b_valid);

  assert_bvalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (o_inv || !o_k0)) |-> out_b_valid);

  assert_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !o_inv && !o_k0) |-> (({1'b0, out_ka} + {1'b0, out_kb}) == o_len));

  assert_inv_same_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_inv) |-> (out_ka == out_kb));

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!o_sofv && $past(out_ovf)) |-> out_ovf);

  assert_sat_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> out_ovf);

endmodule

bind rbr_rotator rbr_rotator_chk #(.NMAX(NMAX), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_dir(in_dir),
  .in_half(in_half), .in_k(in_k), .out_valid(out_valid), .out_ka(out_ka),
  .out_kb(out_kb), .out_b_valid(out_b_valid), .out_ovf(out_ovf), .sat_evt(sat_evt)
);

// File: tb/tb_rbr_rotator.sv
`timescale 1ns/1ps
module tb_rbr_rotator;

  localparam int W = 24, NMAX = 1024, KW = 10, LAT = 10, DEPTH = 4096;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, in_valid, in_sof, in_dir, in_half;
  logic [KW-1:0] in_k;
  logic signed [W-1:0] in_re, in_im;
  logic out_valid, out_b_valid, out_ovf;
  logic signed [W-1:0] out_a, out_b;
  logic [KW-1:0] out_ka, out_kb;

  rbr_rotator #(.W(W), .TW(18), .NMAX(NMAX), .LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_dir(in_dir),
    .in_half(in_half), .in_k(in_k), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_a(out_a), .out_ka(out_ka), .out_b(out_b),
    .out_kb(out_kb), .out_b_valid(out_b_valid), .out_ovf(out_ovf)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;
  bit stk = 0;

  bit     e_v [DEPTH];
  bit     e_bv [DEPTH];
  bit     e_ovf [DEPTH];
  bit     e_dir [DEPTH];
  longint e_a [DEPTH];
  longint e_b [DEPTH];
  int     e_ka [DEPTH];
  int     e_kb [DEPTH];
  string  e_tag [DEPTH];

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // reference rounding: nearest, ties upward, then clip to 24-bit range
  function automatic longint rs(longint x, output bit sat);
    real r;
    longint q;
    r = $floor(x / 32768.0 + 0.5);
    q = longint'(r);
    sat = 0;
    if (q > 8388607) begin q = 8388607; sat = 1; end
    if (q < -8388608) begin q = -8388608; sat = 1; end
    return q;
  endfunction

  function automatic int rnd(int bits);
    logic [31:0] r;
    r = $urandom;
    return $signed(r) >>> (32 - bits);
  endfunction

  task automatic model(bit sof, bit dir, bit half, int k, int re, int im);
    int n, kk, idx, slot;
    real th;
    longint c, s, a, b, ra, rb;
    bit sa, sb, bv;
    n    = half ? NMAX / 2 : NMAX;
    kk   = k % n;
    idx  = kk * (NMAX / n);
    th   = 3.141592653589793 / 2048.0 * idx;
    c    = longint'($floor($cos(th) * 65536.0 + 0.5));
    s    = longint'($floor($sin(th) * 65536.0 + 0.5));
    a    = re;
    slot = cyc + LAT;
    if (!dir) begin
      b  = im;
      ra = rs(a * c + b * s, sa);
      rb = rs(a * s - b * c, sb);
      bv = (kk != 0);
      e_kb[slot] = (kk == 0) ? 0 : n - kk;
    end else begin
      b  = (kk == 0) ? 0 : -longint'(im);
      ra = rs(a * c - b * s, sa);
      rb = rs(b * c + a * s, sb);
      bv = 1;
      e_kb[slot] = kk;
    end
    if (sof) stk = 0;
    stk = stk | sa | (bv & sb);
    e_v[slot] = 1; e_bv[slot] = bv; e_a[slot] = ra; e_b[slot] = rb;
    e_ka[slot] = kk; e_ovf[slot] = stk; e_dir[slot] = dir;
    e_tag[slot] = dir ? "R4" : "R1";
    if (half) e_tag[slot] = {e_tag[slot], "/R6"};
    if (sa | sb) e_tag[slot] = {e_tag[slot], "/R7"};
  endtask

  task automatic compare();
    chk("R5", "out_valid", out_valid, e_v[cyc]);
    if (e_v[cyc]) begin
      chk(e_tag[cyc], "out_a", out_a, e_a[cyc]);
      chk(e_tag[cyc], "out_ka", out_ka, e_ka[cyc]);
      chk("R3", "out_b_valid", out_b_valid, e_bv[cyc]);
      if (e_bv[cyc]) begin
        chk(e_dir[cyc] ? {e_tag[cyc], "/R4"} : {e_tag[cyc], "/R2"}, "out_b", out_b, e_b[cyc]);
        chk(e_dir[cyc] ? "R4" : "R2", "out_kb", out_kb, e_kb[cyc]);
      end else begin
        chk("R3", "out_kb at k=0", out_kb, 0);
      end
      chk("R8", "out_ovf", out_ovf, e_ovf[cyc]);
    end
  endtask

  task automatic step(bit v, bit sof, bit dir, bit half, int k, int re, int im);
    @(negedge clk);
    compare();
    in_valid = v; in_sof = sof; in_dir = dir; in_half = half;
    in_k = KW'(k); in_re = W'(re); in_im = W'(im);
    if (v && rst_n) model(sof, dir, half, k, re, im);
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) e_v[i] = 0;
    rst_n = 0; in_valid = 0; in_sof = 0; in_dir = 0; in_half = 0;
    in_k = '0; in_re = '0; in_im = '0;
    idle(4);
    chk("R9", "out_valid in reset", out_valid, 0);
    chk("R9", "out_b_valid in reset", out_b_valid, 0);
    chk("R9", "out_ovf in reset", out_ovf, 0);
    rst_n = 1;
    idle(3);

    // forward, length 1024, edge indices and random bins, back to back
    step(1, 1, 0, 0, 0, 1000000, -2000000);
    step(1, 0, 0, 0, 1, 3000000, 500000);
    step(1, 0, 0, 0, 1023, -4000000, 4000000);
    step(1, 0, 0, 0, 512, 2500000, -2500000);
    for (int i = 0; i < 30; i++) step(1, 0, 0, 0, $urandom % 1024, rnd(22), rnd(22));
    idle(2);

    // forward, length 512, including index bit 9 set (must be ignored)
    step(1, 1, 0, 1, 0, 700000, 900000);
    step(1, 0, 0, 1, 511, -1500000, 1200000);
    step(1, 0, 0, 1, 512 + 37, 2000000, -3000000);
    step(1, 0, 0, 1, 512, 1234567, 7654321 / 4);
    for (int i = 0; i < 20; i++) step(1, 0, 0, 1, $urandom % 1024, rnd(22), rnd(22));

    // inverse, both lengths, k=0 forces X(N) to zero
    step(1, 1, 1, 0, 0, 3000000, -3000000);
    step(1, 0, 1, 0, 5, -8388608, 8388607 / 3);
    step(1, 0, 1, 1, 0, -2000000, 6000000);
    step(1, 0, 1, 1, 700, 1500000, -1000000);
    for (int i = 0; i < 20; i++) step(1, 0, 1, $urandom % 2, $urandom % 1024, rnd(22), rnd(22));

    // saturation and sticky flag across blocks
    step(1, 1, 0, 0, 10, 1000, 2000);
    step(1, 0, 0, 0, 100, 8388607, 8388607);
    step(1, 0, 0, 0, 200, 1000, -1000);
    step(0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 300, 5000, 5000);
    step(1, 1, 0, 0, 400, 3000, -3000);
    step(1, 0, 1, 0, 50, -8388608, -8388608);
    step(1, 1, 0, 0, 0, -8388608, 8388607);
    step(1, 0, 0, 0, 7, 100, 100);
    step(1, 1, 0, 0, 9, 100, 100);

    // gaps and alternating directions, full-scale values
    for (int i = 0; i < 60; i++)
      step($urandom % 3 != 0, $urandom % 8 == 0, i % 2, $urandom % 2,
           $urandom % 1024, rnd(24), rnd(24));

    idle(LAT + 3);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule